// File: doc/BRIEF.md
# Thermal Alarm Pin Controller

This block turns the window and critical status flags of a temperature comparator into the drive for two open-drain alarm pins. It does not compute the flags and has no bus logic. The flags arrive from upstream, together with a one-cycle strobe that marks the end of each conversion and a one-cycle strobe that marks a host read. Each pin output is a pull-low enable. A pad drives the line low while the enable is high and releases the line otherwise.

The window-alarm pin has two modes, selected by an input.

- **Level-following mode.** The window alarm copies the state of the window flags at every conversion strobe. A host read clears it only until the next conversion re-evaluates the flags.
- **Change-capture mode.** A change in either window flag between consecutive conversion strobes latches the alarm. It stays latched until a host read. After the read it stays clear until a further flag change occurs.

The critical pin tracks the critical flag, and host reads do not touch it. Each pin has its own polarity input. A shutdown input forces both alarms inactive and suspends evaluation.

Top module: `therm_alarm_pins`

## Requirements
- R1: After reset, both internal alarms are inactive, the saved window-flag history is zero and, with both polarity inputs 0, neither pull-low enable is asserted.
- R2: In level-following mode (`int_event_mode`=0), a conversion strobe outside shutdown sets the window alarm, one cycle later, to `flag_hi` OR `flag_lo` as they stand at the strobe.
- R3: In level-following mode, a host read with no conversion strobe in the same cycle clears the window alarm until the next strobe. When a read and a strobe coincide, the strobe's evaluation is the result.
- R4: In change-capture mode (`int_event_mode`=1), a conversion strobe at which `flag_hi` or `flag_lo` differs from its value at the previous accepted strobe sets the window alarm. Before the first strobe after reset, both saved flags count as 0.
- R5: In change-capture mode, a host read clears the window alarm. The alarm stays clear across strobes that bring no flag change. A change in the same cycle as a read leaves the alarm set.
- R6: In both modes, the window alarm holds its value in any cycle without a strobe, read or shutdown, whatever the flags do.
- R7: Outside shutdown, the critical alarm equals `flag_crit` delayed by one clock cycle, and host reads have no effect on it.
- R8: A polarity input of 0 gives active-low, so the pull-low enable equals the alarm. A polarity input of 1 gives active-high, so the pull-low enable is the inverse of the alarm. Polarity acts combinationally and each pin has its own input.
- R9: While `shutdown` is 1, both alarms are cleared from the next cycle on. Conversion strobes are ignored and leave the saved flag history unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_hi | input | 1 | Upper window limit flag |
| flag_lo | input | 1 | Lower window limit flag |
| flag_crit | input | 1 | Critical limit flag |
| conv_done | input | 1 | One-cycle end-of-conversion strobe |
| host_rd | input | 1 | One-cycle host read strobe |
| int_event_mode | input | 1 | 0 level-following, 1 change-capture |
| int_act_high | input | 1 | Window pin polarity, 1 active-high |
| crit_act_high | input | 1 | Critical pin polarity, 1 active-high |
| shutdown | input | 1 | Shutdown request |
| int_pull_lo | output | 1 | Pull-low enable of the window pin |
| crit_pull_lo | output | 1 | Pull-low enable of the critical pin |

## Verification
The hardest case to reach is in change-capture mode. A read must clear a latched alarm while the condition persists, and the alarm must then stay clear through later strobes. This depends on the saved flag history at the last accepted strobe, and that history is not visible at the ports. The stimulus reaches this case in two ways. A directed sequence raises a flag, strobes, reads, and strobes again with the flags unchanged. A long pseudo-random run of strobes, reads, mode changes, polarity changes and shutdown windows is compared every cycle against a bench model that keeps its own copy of the flag history. The shutdown windows check that the history survives strobes the block ignores.

// File: rtl/therm_alarm_pins.sv
module therm_alarm_pins (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_hi,
  input  logic flag_lo,
  input  logic flag_crit,
  input  logic conv_done,
  input  logic host_rd,
  input  logic int_event_mode,
  input  logic int_act_high,
  input  logic crit_act_high,
  input  logic shutdown,
  output logic int_pull_lo,
  output logic crit_pull_lo
);

  logic int_q, crit_q;
  logic seen_hi, seen_lo;
  logic strobe, changed, win_next;

  assign strobe  = conv_done & ~shutdown;
  assign changed = (flag_hi ^ seen_hi) | (flag_lo ^ seen_lo);

  always_comb begin
    win_next = int_q;
    if (host_rd) win_next = 1'b0;
    if (strobe) begin
      if (int_event_mode) win_next = changed | (int_q & ~host_rd);
      else                win_next = flag_hi | flag_lo;
    end
    if (shutdown) win_next = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q   <= 1'b0;
      crit_q  <= 1'b0;
      seen_hi <= 1'b0;
      seen_lo <= 1'b0;
    end else begin
      int_q  <= win_next;
      crit_q <= flag_crit & ~shutdown;
      if (strobe) begin
        seen_hi <= flag_hi;
        seen_lo <= flag_lo;
      end
    end
  end

  assign int_pull_lo  = int_q ^ int_act_high;
  assign crit_pull_lo = crit_q ^ crit_act_high;

  a_r2_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && !shutdown && !int_event_mode && (flag_hi || flag_lo) |=> int_q);

  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd && !conv_done |=> !int_q);

  a_r5_rise_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_q) |-> $past(conv_done) && !$past(shutdown));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_done && !host_rd && !shutdown |=> $stable(int_q));

  a_r7_crit_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !shutdown && flag_crit |=> crit_q);

  a_r9_shutdown_clears: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> !int_q && !crit_q);

endmodule

// File: tb/tb_therm_alarm_pins.sv
module tb_therm_alarm_pins;
  logic clk = 0, rst_n = 0;
  logic flag_hi = 0, flag_lo = 0, flag_crit = 0, conv_done = 0, host_rd = 0;
  logic int_event_mode = 0, int_act_high = 0, crit_act_high = 0, shutdown = 0;
  logic int_pull_lo, crit_pull_lo;
  int checks = 0, failures = 0, cycles = 0;
  logic m_int = 0, m_crit = 0, m_hi = 0, m_lo = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  always #2.5 clk = ~clk;

  therm_alarm_pins dut (.*);

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic cyc(input logic hi, lo, cr, cd, rd, sd);
    logic ev;
    @(negedge clk);
    flag_hi = hi; flag_lo = lo; flag_crit = cr; conv_done = cd; host_rd = rd; shutdown = sd;
    @(posedge clk);
    cycles++;
    if (sd) begin
      m_int = 0; m_crit = 0;
    end else begin
      m_crit = cr;
      if (cd) begin
        ev = (hi != m_hi) || (lo != m_lo);
        m_hi = hi; m_lo = lo;
        m_int = int_event_mode ? (ev || (m_int && !rd)) : (hi || lo);
      end else if (rd) m_int = 0;
    end
    #1;
  endtask

  task automatic check_pins(input string itag, input string ctag);
    chk(int_pull_lo, m_int ^ int_act_high, itag);
    chk(crit_pull_lo, m_crit ^ crit_act_high, ctag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(int_pull_lo, 1'b0, "R1 reset window pin");
    chk(crit_pull_lo, 1'b0, "R1 reset critical pin");
    @(negedge clk) rst_n = 1;

    // level-following directed
    cyc(1,0,0,1,0,0); check_pins("R2 strobe with hi", "R7 crit low");
    cyc(1,0,0,0,1,0); check_pins("R3 read clears", "R7 crit low");
    cyc(0,1,1,0,0,0); check_pins("R6 flags ignored between strobes", "R7 crit follows");
    cyc(0,1,1,1,1,0); check_pins("R3 strobe wins over read", "R7 read no effect on crit");
    cyc(0,0,1,1,0,0); check_pins("R2 strobe no flag", "R7 crit held");

    // change-capture directed
    int_event_mode = 1;
    cyc(1,0,0,1,0,0); check_pins("R4 hi rise latches", "R7 crit low");
    cyc(1,0,0,1,0,0); check_pins("R5 no change keeps latch", "R7 crit low");
    cyc(1,0,0,0,1,0); check_pins("R5 read clears latch", "R7 crit low");
    cyc(1,0,0,1,0,0); check_pins("R5 stays clear while condition holds", "R7 crit low");
    cyc(0,0,0,1,1,0); check_pins("R5 change with read stays set", "R7 crit low");

    // shutdown keeps history
    cyc(0,0,1,0,0,1); check_pins("R9 shutdown clears window", "R9 shutdown clears crit");
    cyc(1,1,1,1,0,1); check_pins("R9 strobe ignored", "R9 crit held off");
    cyc(0,0,0,1,0,0); check_pins("R9 history unchanged", "R7 crit low");

    // polarity
    int_act_high = 1; crit_act_high = 1; #1;
    check_pins("R8 active-high window", "R8 active-high crit");
    int_act_high = 0; #1;
    check_pins("R8 independent polarity", "R8 crit polarity kept");

    // pseudo-random sweep
    for (int i = 0; i < 6000; i++) begin
      logic [15:0] r;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = lfsr;
      if (i % 700 == 0) int_event_mode = ~int_event_mode;
      if (i % 333 == 0) begin int_act_high = r[9]; crit_act_high = r[10]; end
      cyc(r[0], r[1] & r[2], r[3], r[4] & r[5], r[6] & r[7] & r[8], (r[15:11] == 5'd0));
      if (shutdown) check_pins("R9 sweep window", "R9 sweep crit");
      else if (int_event_mode) check_pins("R4 R5 sweep change-capture", "R7 sweep crit");
      else check_pins("R2 R3 sweep level-following", "R7 sweep crit");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule